// File: doc/BRIEF.md
# ADC Start Request and Interrupt Gate

This block sits between the trigger sources of an analog-to-digital converter and its two conversion sequencers. It gathers start requests from a software command bit, two timer-event pulses (event source A and event source B) and an asynchronous external start pin. It routes each request to the first or the second sequencer according to the sequencer mode and a set of per-source enables. Accepted requests are held as pending flags and released as one-cycle start pulses as soon as the target sequencer reports idle.

On the return path it takes the end-of-sequence pulses from each sequencer and turns them into interrupt pulses. Each sequencer has its own enable and its own decimation mode, so an interrupt can follow every end of sequence or only every second one. The block also provides self-clearing command bits: a module-wide soft reset and a per-sequencer reset, each of which asserts for exactly one cycle.

The sequencers and the interrupt controller are outside this block. Write strobes and values come from a register file that is not part of the block.

Top module: `adc_trig_irq_gate`

## Requirements
- R1: Sequencer 1 gets a pending request from a software write with value 1, from an event-A pulse when `eva_en1` is 1, and from an external-pin rising edge when `ext_en1` is 1. A source whose enable is 0 leaves the pending flag unchanged.
- R2: An event-B pulse sets sequencer 1 pending only when `chain_mode` is 1 (cascaded) and `evb_en1` is 1. When `chain_mode` is 0 (dual), it sets sequencer 2 pending only when `evb_en2` is 1. In cascaded mode nothing sets sequencer 2 pending.
- R3: A software write with value 1 to the sequencer 2 start bit sets sequencer 2 pending only in dual mode. In cascaded mode it has no effect.
- R4: A software write with value 0 to a start bit clears that sequencer's pending flag at the next edge. It takes priority over any trigger for the same sequencer in the same cycle.
- R5: A request sampled at edge k shows as pending after edge k. If `seq_idle` is 1 at edge k+1, `start` is high for the one cycle after edge k+1 and pending drops at that same edge. While `seq_idle` is 0, pending holds and no start is issued.
- R6: The external pin passes through a two-stage synchronizer and a rising-edge detector. A pin that goes high before edge k sets pending after edge k+2. A pin held high produces only one request.
- R7: With `irq_mode` 0, an end-of-sequence pulse sampled at an edge gives a one-cycle `irq` pulse right after that edge.
- R8: A mode write with value 1 selects every-second operation: `irq` follows only the second, fourth and later end-of-sequence pulses. The mode write, and a sequencer reset write, clear the every-other count to zero.
- R9: No `irq` pulse appears for a sequencer whose `irq_en` was 0 at the sampling edge.
- R10: A write to `mod_rst_wr` raises `mod_rst_busy` for exactly one cycle. At the end of that cycle, all pending flags, start and interrupt outputs, stored interrupt modes and every-other counts are zero.
- R11: A write to `seq_rst_wr[i]` clears that sequencer's pending flag and its every-other count at the same edge. It also raises `seq_rst[i]` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_mode | input | 1 | 1 = cascaded (single long sequencer), 0 = dual sequencers |
| sw_wr | input | 2 | Write strobe for the software start bit, one per sequencer |
| sw_val | input | 2 | Value written: 1 starts, 0 clears the pending request |
| eva_trig | input | 1 | Event source A trigger pulse |
| evb_trig | input | 1 | Event source B trigger pulse |
| ext_pin | input | 1 | Asynchronous external start pin |
| eva_en1 | input | 1 | Event A may start sequencer 1 |
| evb_en1 | input | 1 | Event B may start sequencer 1 (cascaded mode) |
| evb_en2 | input | 1 | Event B may start sequencer 2 (dual mode) |
| ext_en1 | input | 1 | External pin may start sequencer 1 |
| seq_idle | input | 2 | Sequencer ready to take a start |
| seq_rst_wr | input | 2 | Sequencer reset command write |
| mod_rst_wr | input | 1 | Module soft reset command write |
| eos | input | 2 | End-of-sequence pulses from the sequencers |
| irq_en | input | 2 | Interrupt enable per sequencer |
| irq_mode_wr | input | 2 | Write strobe for the interrupt mode bit |
| irq_mode_val | input | 2 | Mode written: 0 every end, 1 every second end |
| start | output | 2 | One-cycle start pulse per sequencer |
| pending | output | 2 | Pending request flag per sequencer |
| irq | output | 2 | One-cycle interrupt request per sequencer |
| seq_rst | output | 2 | Self-clearing sequencer reset bit |
| mod_rst_busy | output | 1 | Self-clearing module reset bit |
| irq_mode | output | 2 | Stored interrupt mode per sequencer |

## Verification
The bound checker checks these properties on every cycle:
- a start pulse always follows a cycle in which the request was pending and the sequencer was idle;
- sequencer 2 never gains a request while the mode is cascaded;
- no interrupt follows a disabled enable;
- both self-clearing bits last a single cycle, and the soft reset leaves pending flags and interrupts cleared.

Only the bench's scenarios can show:
- the routing matrix across modes and enables, and the priority of a clear write over a trigger;
- the synchronizer latency and the single start for a held pin;
- the counting of every second end of sequence, and its restart after mode writes and sequencer resets.

// File: rtl/trig_gate_pkg.sv
package trig_gate_pkg;
  localparam int unsigned NSEQ = 2;
  localparam int unsigned SQ1  = 0;
  localparam int unsigned SQ2  = 1;

  typedef struct packed {
    logic ext1;
    logic evb2;
    logic evb1;
    logic eva1;
  } src_en_t;
endpackage

// File: rtl/tg_ext_sync.sv
module tg_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              last_q, last_d;

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], pin};
    last_d = sh_q[STAGES-1];
    rise   = sh_q[STAGES-1] & ~last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/tg_route.sv
module tg_route
  import trig_gate_pkg::*;
(
  input  logic            chain,
  input  logic [NSEQ-1:0] sw_wr,
  input  logic [NSEQ-1:0] sw_val,
  input  logic            eva,
  input  logic            evb,
  input  logic            ext_rise,
  input  src_en_t         en,
  output logic [NSEQ-1:0] set,
  output logic [NSEQ-1:0] clr
);
  always_comb begin
    set[SQ1] = (sw_wr[SQ1] & sw_val[SQ1])
             | (eva & en.eva1)
             | (ext_rise & en.ext1)
             | (chain & evb & en.evb1);
    set[SQ2] = ~chain & ((sw_wr[SQ2] & sw_val[SQ2]) | (evb & en.evb2));
    clr      = sw_wr & ~sw_val;
  end
endmodule

// File: rtl/tg_pend_slot.sv
module tg_pend_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic idle,
  output logic pend,
  output logic start
);
  logic pend_q, pend_d;
  logic start_q, start_d;

  always_comb begin
    if (clr) begin
      pend_d  = 1'b0;
      start_d = 1'b0;
    end else begin
      start_d = pend_q & idle;
      pend_d  = set | (pend_q & ~idle);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      start_q <= start_d;
    end
  end

  assign pend  = pend_q;
  assign start = start_q;
endmodule

// File: rtl/tg_irq_decim.sv
module tg_irq_decim #(
  parameter int unsigned DECIM = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic cnt_clr,
  input  logic eos,
  input  logic en,
  input  logic mode_wr,
  input  logic mode_val,
  output logic irq,
  output logic mode
);
  localparam int unsigned CW = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [CW-1:0] LAST = CW'(DECIM - 1);

  logic          mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          irq_q, irq_d;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    irq_d  = 1'b0;
    if (soft_clr) begin
      mode_d = 1'b0;
      cnt_d  = '0;
    end else if (mode_wr || cnt_clr) begin
      if (mode_wr) mode_d = mode_val;
      cnt_d = '0;
    end else if (eos) begin
      if (!mode_q) begin
        irq_d = en;
      end else if (cnt_q == LAST) begin
        cnt_d = '0;
        irq_d = en;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      irq_q  <= irq_d;
    end
  end

  assign irq  = irq_q;
  assign mode = mode_q;
endmodule

// File: rtl/adc_trig_irq_gate.sv
module adc_trig_irq_gate
  import trig_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IRQ_DECIM   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chain_mode,
  input  logic [1:0] sw_wr,
  input  logic [1:0] sw_val,
  input  logic       eva_trig,
  input  logic       evb_trig,
  input  logic       ext_pin,
  input  logic       eva_en1,
  input  logic       evb_en1,
  input  logic       evb_en2,
  input  logic       ext_en1,
  input  logic [1:0] seq_idle,
  input  logic [1:0] seq_rst_wr,
  input  logic       mod_rst_wr,
  input  logic [1:0] eos,
  input  logic [1:0] irq_en,
  input  logic [1:0] irq_mode_wr,
  input  logic [1:0] irq_mode_val,
  output logic [1:0] start,
  output logic [1:0] pending,
  output logic [1:0] irq,
  output logic [1:0] seq_rst,
  output logic       mod_rst_busy,
  output logic [1:0] irq_mode
);
  src_en_t         en;
  logic            ext_rise;
  logic [NSEQ-1:0] set, sw_clr, pend_clr;
  logic            mrst_q, mrst_d;
  logic [NSEQ-1:0] srst_q, srst_d;

  assign en = '{ext1: ext_en1, evb2: evb_en2, evb1: evb_en1, eva1: eva_en1};

  tg_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(ext_rise)
  );

  tg_route u_route (
    .chain(chain_mode), .sw_wr(sw_wr), .sw_val(sw_val),
    .eva(eva_trig), .evb(evb_trig), .ext_rise(ext_rise),
    .en(en), .set(set), .clr(sw_clr)
  );

  always_comb begin
    mrst_d   = mod_rst_wr & ~mrst_q;
    srst_d   = mrst_q ? '0 : (seq_rst_wr & ~srst_q);
    pend_clr = sw_clr | seq_rst_wr | {NSEQ{mrst_q}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrst_q <= 1'b0;
      srst_q <= '0;
    end else begin
      mrst_q <= mrst_d;
      srst_q <= srst_d;
    end
  end

  for (genvar i = 0; i < NSEQ; i++) begin : g_seq
    tg_pend_slot u_pend (
      .clk(clk), .rst_n(rst_n), .set(set[i]), .clr(pend_clr[i]),
      .idle(seq_idle[i]), .pend(pending[i]), .start(start[i])
    );
    tg_irq_decim #(.DECIM(IRQ_DECIM)) u_irq (
      .clk(clk), .rst_n(rst_n), .soft_clr(mrst_q), .cnt_clr(seq_rst_wr[i]),
      .eos(eos[i]), .en(irq_en[i]), .mode_wr(irq_mode_wr[i]),
      .mode_val(irq_mode_val[i]), .irq(irq[i]), .mode(irq_mode[i])
    );
  end

  assign mod_rst_busy = mrst_q;
  assign seq_rst      = srst_q;
endmodule

// File: rtl/adc_trig_irq_gate_chk.sv
module adc_trig_irq_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chain_mode,
  input logic [1:0] seq_idle,
  input logic [1:0] irq_en,
  input logic [1:0] start,
  input logic [1:0] pending,
  input logic [1:0] irq,
  input logic [1:0] seq_rst,
  input logic       mod_rst_busy
);
  // R5
  start0_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start[0] |-> ($past(pending[0]) && $past(seq_idle[0])));
  // R5
  start1_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start[1] |-> ($past(pending[1]) && $past(seq_idle[1])));
  // R2 R3
  no_seq2_in_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chain_mode) && !$past(pending[1])) |-> !pending[1]);
  // R9
  irq0_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(irq_en[0]) |-> !irq[0]);
  // R9
  irq1_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(irq_en[1]) |-> !irq[1]);
  // R10
  mod_rst_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst_busy |=> (!mod_rst_busy && pending == 2'b00 && irq == 2'b00 && start == 2'b00));
  // R11
  seq_rst0_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rst[0] |-> (!pending[0] ##1 !seq_rst[0]));
  // R11
  seq_rst1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rst[1] |-> (!pending[1] ##1 !seq_rst[1]));
endmodule

bind adc_trig_irq_gate adc_trig_irq_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chain_mode(chain_mode), .seq_idle(seq_idle),
  .irq_en(irq_en), .start(start), .pending(pending), .irq(irq),
  .seq_rst(seq_rst), .mod_rst_busy(mod_rst_busy)
);

// File: tb/tb_adc_trig_irq_gate.sv
`timescale 1ns/1ps
module tb_adc_trig_irq_gate;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       chain_mode, eva_trig, evb_trig, ext_pin;
  logic       eva_en1, evb_en1, evb_en2, ext_en1, mod_rst_wr;
  logic [1:0] sw_wr, sw_val, seq_idle, seq_rst_wr, eos, irq_en, irq_mode_wr, irq_mode_val;
  logic [1:0] start, pending, irq, seq_rst, irq_mode;
  logic       mod_rst_busy;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 0;

  adc_trig_irq_gate dut (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 50000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // {chain, eva, evb, sw_wr[1:0], sw_val[1:0], en{ext1,evb2,evb1,eva1}, expected pending[1:0]}
  localparam logic [12:0] VEC [12] = '{
    13'b0_0_0_01_01_0000_01,  // R1 software start seq1
    13'b0_1_0_00_00_0001_01,  // R1 event A enabled
    13'b0_1_0_00_00_0000_00,  // R1 event A masked
    13'b0_0_1_00_00_0100_10,  // R2 event B to seq2 in dual
    13'b0_0_1_00_00_0010_00,  // R2 seq1 B enable ignored in dual
    13'b1_0_1_00_00_0010_01,  // R2 event B to seq1 in cascaded
    13'b1_0_1_00_00_0100_00,  // R2 seq2 B enable ignored in cascaded
    13'b1_0_0_10_10_0000_00,  // R3 seq2 software start ignored in cascaded
    13'b0_0_0_10_10_0000_10,  // R3 seq2 software start in dual
    13'b0_1_1_00_00_0111_11,  // R1 R2 both
    13'b1_1_1_00_00_0111_01,  // R2 cascaded both
    13'b0_0_1_11_01_0100_01   // R4 clear beats event B
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    sw_wr = 0; sw_val = 0; eva_trig = 0; evb_trig = 0;
    seq_rst_wr = 0; mod_rst_wr = 0; eos = 0; irq_mode_wr = 0; irq_mode_val = 0;
  endtask

  task automatic eos_pulse(input int s, input logic exp_irq, input string req);
    eos[s] = 1'b1; tick(); eos[s] = 1'b0;
    chk(req, irq[s], exp_irq);
  endtask

  initial begin
    rst_n = 0; chain_mode = 0; ext_pin = 0; seq_idle = 0; irq_en = 0;
    eva_en1 = 0; evb_en1 = 0; evb_en2 = 0; ext_en1 = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk("reset pending", pending, 0);
    chk("reset start", start, 0);
    chk("reset irq", irq, 0);
    chk("reset R10 busy", mod_rst_busy, 0);
    chk("reset R11 seq_rst", seq_rst, 0);
    chk("reset mode", irq_mode, 0);

    // routing table
    for (int i = 0; i < 12; i++) begin
      logic [12:0] v;
      v = VEC[i];
      chain_mode = v[12]; eva_trig = v[11]; evb_trig = v[10];
      sw_wr = v[9:8]; sw_val = v[7:6];
      {ext_en1, evb_en2, evb_en1, eva_en1} = v[5:2];
      tick();
      chk($sformatf("R1/R2/R3/R4 row%0d", i), pending, v[1:0]);
      idle_inputs(); sw_wr = 2'b11; sw_val = 2'b00;
      tick();
      chk($sformatf("R4 clear row%0d", i), pending, 0);
      sw_wr = 0;
    end
    chain_mode = 0; {ext_en1, evb_en2, evb_en1, eva_en1} = 4'b0;

    // R5 start handshake while busy then idle
    sw_wr = 2'b01; sw_val = 2'b01; tick(); sw_wr = 0;
    chk("R5 pend set", pending[0], 1);
    tick(); tick();
    chk("R5 held busy", {start[0], pending[0]}, 2'b01);
    seq_idle[0] = 1; tick();
    chk("R5 start", {start[0], pending[0]}, 2'b10);
    tick();
    chk("R5 start one cycle", start[0], 0);
    sw_wr = 2'b10; sw_val = 2'b10; seq_idle[1] = 1; tick(); sw_wr = 0;
    chk("R5 seq2 pend", {start[1], pending[1]}, 2'b01);
    tick();
    chk("R5 seq2 start", {start[1], pending[1]}, 2'b10);
    seq_idle = 0; tick();

    // R6 external pin
    ext_en1 = 1; ext_pin = 1;
    tick(); tick();
    chk("R6 not yet", pending[0], 0);
    tick();
    chk("R6 pend after sync", pending[0], 1);
    sw_wr = 2'b01; sw_val = 2'b00; tick(); sw_wr = 0;
    repeat (4) tick();
    chk("R6 held pin one request", pending[0], 0);
    ext_pin = 0; repeat (4) tick();
    ext_en1 = 0; ext_pin = 1; repeat (5) tick();
    chk("R1 ext masked", pending[0], 0);
    ext_pin = 0; repeat (4) tick();

    // R7 / R9
    irq_en = 2'b01;
    eos_pulse(0, 1, "R7 irq every eos");
    tick();
    chk("R7 irq one cycle", irq[0], 0);
    eos_pulse(0, 1, "R7 second eos");
    eos_pulse(1, 0, "R9 seq2 disabled");
    irq_en = 2'b11;
    eos_pulse(1, 1, "R7 seq2 enabled");

    // R8 decimation
    irq_mode_wr = 2'b01; irq_mode_val = 2'b01; tick(); irq_mode_wr = 0;
    chk("R8 mode stored", irq_mode, 2'b01);
    eos_pulse(0, 0, "R8 first eos silent");
    eos_pulse(0, 1, "R8 second eos fires");
    eos_pulse(0, 0, "R8 third eos silent");
    eos_pulse(0, 1, "R8 fourth eos fires");
    eos_pulse(0, 0, "R8 odd before rewrite");
    irq_mode_wr = 2'b01; irq_mode_val = 2'b01; tick(); irq_mode_wr = 0;
    eos_pulse(0, 0, "R8 count cleared by mode write");
    eos_pulse(0, 1, "R8 fires after rewrite");
    eos_pulse(0, 0, "R8 odd before seq reset");
    seq_rst_wr = 2'b01; tick(); seq_rst_wr = 0;
    chk("R11 seq_rst pulse", seq_rst, 2'b01);
    tick();
    chk("R11 seq_rst self clears", seq_rst, 2'b00);
    eos_pulse(0, 0, "R8 count cleared by seq reset");
    eos_pulse(0, 1, "R8 fires after seq reset");
    irq_en = 2'b00;
    eos_pulse(0, 0, "R9 masked in mode 1");
    eos_pulse(0, 0, "R9 masked in mode 1 even");

    // R11 clears pending
    sw_wr = 2'b10; sw_val = 2'b10; tick(); sw_wr = 0;
    chk("R11 pend before", pending[1], 1);
    seq_rst_wr = 2'b10; tick(); seq_rst_wr = 0;
    chk("R11 pend cleared", {seq_rst[1], pending[1]}, 2'b10);

    // R10 module reset
    irq_mode_wr = 2'b10; irq_mode_val = 2'b10; sw_wr = 2'b11; sw_val = 2'b11; tick();
    irq_mode_wr = 0; sw_wr = 0;
    chk("R10 pre state", {irq_mode, pending}, 4'b1111);
    mod_rst_wr = 1; tick(); mod_rst_wr = 0;
    chk("R10 busy", mod_rst_busy, 1);
    tick();
    chk("R10 self clear", mod_rst_busy, 0);
    chk("R10 state cleared", {irq_mode, pending}, 4'b0000);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule